// File: doc/BRIEF.md
# Multi-Channel Down-Counting Bus Timer

A bank of independent down-counting timers, each one 32 bits wide, reached through a simple memory-mapped read/write bus with a setup phase and an access phase. Every channel has four registers: a load count, a live current value, a control word and an end-of-interrupt register that clears on read. A fifth per-channel register reports the masked interrupt. Each channel drives its own interrupt line. A shared group placed after the last channel gives a read-to-clear for all channels, the masked and raw interrupt status of every channel, and a fixed version word.

Software stops a channel, writes its load count, then sets enable. The current value is taken from the load count on the write that raises enable, and from then on it falls by one on each clock. When a running channel is at zero, the next clock expires it. In periodic mode the count restarts from the load count. In free-running mode it restarts from the all-ones value, which gives the longest time to the next expiry. An expiry always latches the channel's raw status bit, even while its interrupt is masked. The interrupt line is the raw bit gated by the mask.

Top module: `cdtimer_bank`

## Requirements
- R1: After reset, every channel's control, load count and current value read as zero, and every interrupt output is low.
- R2: On the write that raises enable from 0 to 1, the current value is loaded from the load count. On every later clock with enable high, it falls by one.
- R3: While enable is low, the current value holds its value, and a write to the load count does not change it.
- R4: In periodic mode (control bit 1 = 1), a running channel at zero reloads the load count on the next clock and sets its raw status bit, so the expiries of a load count L come every L+1 clocks.
- R5: In free-running mode (control bit 1 = 0), a running channel at zero reloads 0xFFFF_FFFF on the next clock and sets its raw status bit.
- R6: The control bits are: bit 0 enable, bit 1 mode, bit 2 interrupt mask (1 = masked). A channel's interrupt output equals its raw bit when bit 2 is 0 and is low when bit 2 is 1.
- R7: An expiry sets the channel's raw bit even while the channel is masked. The shared raw status register shows channel n in bit n.
- R8: A read of a channel's end-of-interrupt register clears that channel's raw bit and interrupt, and leaves the other channels unchanged. If an expiry falls in the same clock, the expiry wins.
- R9: The registers of channel n start at byte address n*0x14. Within a group, 0x00 is the load count, 0x04 the current value, 0x08 control, 0x0C end-of-interrupt and 0x10 the masked interrupt of that channel.
- R10: The shared group starts at N*0x14. Its offsets are 0x00 for the all-channel end-of-interrupt, 0x04 for masked status, 0x08 for raw status and 0x0C for the version word, which reads the VERSION parameter.
- R11: A read of the shared end-of-interrupt register clears the raw bits of all channels.
- R12: The masked status register and each channel's register at 0x10 read the raw bits ANDed with the inverted mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and counters |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select, high in setup and access phases |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid in the access phase |
| irq_o | output | N_CH (4) | Interrupt line of each channel |

## Verification
A write takes effect on the clock edge that ends its access phase. Read data is combinational from the registers, so the bench samples it 1 ns after the falling edge that opens the access phase. Counting from the end of a write, a read that follows at once sees the current value two clocks later, so the expected value is L-2, and back-to-back reads of a running channel differ by 3. An interrupt rises L+1 clocks after the enabling edge. The bench counts rising edges on its own counter to check this, and to check the gap of L+1 clocks between periodic expiries.

// File: rtl/cdt_pkg.sv
// Package: register offsets and the control word type for the timer bank.
// Assumes word-aligned byte addressing.
package cdt_pkg;
    // Offsets inside one channel group
    localparam int OFF_LOAD = 'h00;
    localparam int OFF_CUR  = 'h04;
    localparam int OFF_CTRL = 'h08;
    localparam int OFF_EOI  = 'h0C;
    localparam int OFF_STAT = 'h10;
    localparam int CH_STRIDE = 'h14;
    // Offsets inside the shared group
    localparam int GOFF_EOI  = 'h00;
    localparam int GOFF_MSTAT = 'h04;
    localparam int GOFF_RAW  = 'h08;
    localparam int GOFF_VER  = 'h0C;
    localparam int GLB_SPAN  = 'h10;

    // Control word: bit0 enable, bit1 periodic mode, bit2 interrupt mask
    typedef struct packed {
        logic mask;
        logic mode;
        logic en;
    } ctrl_t;
    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cdt_decode.sv
// Address decoder: turns a byte address into a one-hot channel select with
// an offset in that group, or a hit on the shared group after the channels.
// Assumes N_CH*STRIDE + GLB_SPAN fits in ADDR_W bits.
module cdt_decode
    import cdt_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 8,
    parameter int STRIDE = CH_STRIDE
) (
    input  logic [ADDR_W-1:0] paddr,
    output logic [N_CH-1:0]   ch_hit,
    output logic [$clog2(STRIDE)-1:0] ch_off,
    output logic              glb_hit,
    output logic [$clog2(GLB_SPAN)-1:0] glb_off
);
    localparam int OFF_W  = $clog2(STRIDE);
    localparam int GOFF_W = $clog2(GLB_SPAN);
    localparam int GLB_BASE = N_CH * STRIDE;

    int addr_i;
    assign addr_i = int'({{(32-ADDR_W){1'b0}}, paddr});

    // Range compare against each channel window and the shared window
    always_comb begin
        ch_hit  = '0;
        ch_off  = '0;
        glb_hit = 1'b0;
        glb_off = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (addr_i >= i * STRIDE && addr_i < (i + 1) * STRIDE) begin
                ch_hit[i] = 1'b1;
                ch_off    = OFF_W'(addr_i - i * STRIDE);
            end
        end
        if (addr_i >= GLB_BASE && addr_i < GLB_BASE + GLB_SPAN) begin
            glb_hit = 1'b1;
            glb_off = GOFF_W'(addr_i - GLB_BASE);
        end
    end
endmodule

// File: rtl/cdt_channel.sv
// One down-counting channel: holds its load count, control word, live count
// and raw expiry flag. Assumes the strobes come in from the decoder, one at
// most per clock.
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    input  logic             eoi_clr,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cur_q,
    output ctrl_t            ctrl_q,
    output logic             raw_q
);
    ctrl_t ctrl_d;
    logic  start;
    logic  expire;

    assign ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    assign start  = wr_ctrl && ctrl_d.en && !ctrl_q.en;
    assign expire = ctrl_q.en && (cur_q == '0);

    // Load count register
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (wr_load) load_q <= wdata;
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_d;
    end

    // Live count: load on enable rise, count down, reload on expiry
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_q <= '0;
        else if (start)      cur_q <= load_q;
        else if (ctrl_q.en) begin
            if (expire)      cur_q <= ctrl_q.mode ? load_q : '1;
            else             cur_q <= cur_q - 1'b1;
        end
    end

    // Raw expiry flag: set on expiry, cleared by an end-of-interrupt read
    always_ff @(posedge clk) begin
        if (!rst_n)       raw_q <= 1'b0;
        else if (expire)  raw_q <= 1'b1;
        else if (eoi_clr) raw_q <= 1'b0;
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && cur_q != '0) |=> (cur_q == $past(cur_q) - 1'b1));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !start) |=> $stable(cur_q));
    // R4
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && ctrl_q.mode && cur_q == '0) |=> (cur_q == $past(load_q)));
    // R5
    free_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && !ctrl_q.mode && cur_q == '0) |=> (cur_q == '1));
    // R7
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && cur_q == '0) |=> raw_q);
    // R8
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_clr && !(ctrl_q.en && cur_q == '0)) |=> !raw_q);
endmodule

// File: rtl/cdtimer_bank.sv
// Timer bank top: bus access phase decode, per-channel strobes, read mux
// and interrupt gating. Assumes a single clock and that reads have no wait
// states (read data is combinational in the access phase).
module cdtimer_bank
    import cdt_pkg::*;
#(
    parameter int          N_CH    = 4,
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] VERSION = 32'h0001_0300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [N_CH-1:0]   irq_o
);
    localparam int OFF_W  = $clog2(CH_STRIDE);
    localparam int GOFF_W = $clog2(GLB_SPAN);

    logic              acc_wr, acc_rd;
    logic [N_CH-1:0]   ch_hit;
    logic [OFF_W-1:0]  ch_off;
    logic              glb_hit;
    logic [GOFF_W-1:0] glb_off;
    logic              glb_eoi;

    logic [DATA_W-1:0] load_v [N_CH];
    logic [DATA_W-1:0] cur_v  [N_CH];
    ctrl_t             ctrl_v [N_CH];
    logic [N_CH-1:0]   raw_v;
    logic [N_CH-1:0]   mask_v;

    assign acc_wr  = psel && penable && pwrite;
    assign acc_rd  = psel && penable && !pwrite;
    assign glb_eoi = acc_rd && glb_hit && (int'(glb_off) == GOFF_EOI);

    cdt_decode #(
        .N_CH  (N_CH),
        .ADDR_W(ADDR_W),
        .STRIDE(CH_STRIDE)
    ) u_decode (
        .paddr  (paddr),
        .ch_hit (ch_hit),
        .ch_off (ch_off),
        .glb_hit(glb_hit),
        .glb_off(glb_off)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic wr_load, wr_ctrl, eoi_clr;
        assign wr_load = acc_wr && ch_hit[g] && (int'(ch_off) == OFF_LOAD);
        assign wr_ctrl = acc_wr && ch_hit[g] && (int'(ch_off) == OFF_CTRL);
        assign eoi_clr = glb_eoi ||
                         (acc_rd && ch_hit[g] && (int'(ch_off) == OFF_EOI));

        cdt_channel #(.CNT_W(DATA_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_load(wr_load),
            .wr_ctrl(wr_ctrl),
            .wdata  (pwdata),
            .eoi_clr(eoi_clr),
            .load_q (load_v[g]),
            .cur_q  (cur_v[g]),
            .ctrl_q (ctrl_v[g]),
            .raw_q  (raw_v[g])
        );

        assign mask_v[g] = ctrl_v[g].mask;

        // R6
        mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_v[g].mask |-> !irq_o[g]);
    end

    // Interrupt lines: raw expiry gated by the mask
    assign irq_o = raw_v & ~mask_v;

    // Read data mux for channel and shared registers
    always_comb begin
        prdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (ch_hit[i]) begin
                case (int'(ch_off))
                    OFF_LOAD: prdata = load_v[i];
                    OFF_CUR:  prdata = cur_v[i];
                    OFF_CTRL: prdata = DATA_W'(ctrl_v[i]);
                    OFF_STAT: prdata = DATA_W'(irq_o[i]);
                    default:  prdata = '0;
                endcase
            end
        end
        if (glb_hit) begin
            case (int'(glb_off))
                GOFF_MSTAT: prdata = DATA_W'(irq_o);
                GOFF_RAW:   prdata = DATA_W'(raw_v);
                GOFF_VER:   prdata = DATA_W'(VERSION);
                default:    prdata = '0;
            endcase
        end
    end

    // R9
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable) |-> ($onehot0(ch_hit) && !(glb_hit && ch_hit != '0)));
endmodule

// File: tb/cdtimer_bank_bench.sv
// Directed bench for the timer bank: one task per scenario.
module cdtimer_bank_bench;
    localparam int N_CH = 4;
    localparam int GB   = N_CH * 'h14;
    localparam logic [31:0] VER = 32'h0001_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [N_CH-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cdtimer_bank #(.N_CH(N_CH), .VERSION(VER)) u_cdtimer_bank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq_o(irq_o)
    );

    function automatic logic [7:0] ca(int ch, int off);
        return 8'(ch * 'h14 + off);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic wait_irq(int ch, output int k);
        k = 0;
        do begin @(posedge clk); #1; k++; end while (!irq_o[ch] && k < 500);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(ca(0, 'h08), d); chk("R1 ctrl", d, 0);
        bus_rd(ca(0, 'h00), d); chk("R1 load", d, 0);
        bus_rd(ca(3, 'h04), d); chk("R1 cur", d, 0);
        chk("R1 irq", 32'(irq_o), 0);
        bus_rd(8'(GB + 'h0C), d); chk("R10 version", d, VER);
    endtask

    task automatic t_count();
        logic [31:0] d, d2;
        bus_wr(ca(2, 'h00), 1000);
        bus_wr(ca(2, 'h08), 3);
        bus_rd(ca(2, 'h04), d);  chk("R2 start value", d, 998);
        bus_rd(ca(2, 'h04), d2); chk("R2 step", d2, 995);
        bus_rd(ca(2, 'h00), d);  chk("R9 ch2 load", d, 1000);
        bus_rd(ca(1, 'h00), d);  chk("R9 ch1 load untouched", d, 0);
    endtask

    task automatic t_hold();
        logic [31:0] a, b;
        bus_wr(ca(2, 'h08), 2);
        bus_rd(ca(2, 'h04), a);
        bus_rd(ca(2, 'h04), b); chk("R3 hold", b, a);
        bus_wr(ca(2, 'h00), 55);
        bus_rd(ca(2, 'h04), b); chk("R3 load write no effect", b, a);
        bus_wr(ca(2, 'h08), 3);
        bus_rd(ca(2, 'h04), b); chk("R2 restart from new load", b, 53);
        bus_wr(ca(2, 'h08), 0);
    endtask

    task automatic t_periodic();
        int k, t1, t2;
        logic [31:0] d;
        bus_wr(ca(0, 'h00), 10);
        bus_wr(ca(0, 'h08), 3);
        wait_irq(0, k); t1 = cyc;
        chk("R4 first expiry", 32'(k), 11);
        bus_rd(ca(0, 'h10), d); chk("R12 ch0 status", d, 1);
        bus_rd(ca(0, 'h0C), d);
        chk("R8 eoi clears irq", 32'(irq_o[0]), 0);
        wait_irq(0, k); t2 = cyc;
        chk("R4 period", 32'(t2 - t1), 11);
        bus_rd(ca(0, 'h0C), d);
        bus_wr(ca(0, 'h08), 0);
        bus_rd(ca(0, 'h10), d); chk("R12 ch0 status cleared", d, 0);
    endtask

    task automatic t_free();
        int k;
        logic [31:0] d;
        bus_wr(ca(1, 'h00), 5);
        bus_wr(ca(1, 'h08), 1);
        wait_irq(1, k);
        chk("R5 expiry time", 32'(k), 6);
        bus_rd(ca(1, 'h04), d); chk("R5 all-ones reload", d, 32'hFFFF_FFFE);
        bus_rd(ca(1, 'h0C), d);
        bus_wr(ca(1, 'h08), 0);
        bus_rd(8'(GB + 'h08), d); chk("R8 raw cleared", d, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bus_wr(ca(3, 'h00), 4);
        bus_wr(ca(3, 'h08), 5);
        repeat (10) @(negedge clk);
        chk("R6 masked irq low", 32'(irq_o[3]), 0);
        bus_rd(8'(GB + 'h08), d); chk("R7 raw while masked", d, 32'h8);
        bus_rd(ca(3, 'h10), d);   chk("R12 ch3 masked status", d, 0);
        bus_rd(8'(GB + 'h04), d); chk("R12 shared masked status", d, 0);
        bus_wr(ca(3, 'h08), 1);
        chk("R6 unmask raises irq", 32'(irq_o[3]), 1);
        bus_rd(8'(GB + 'h04), d); chk("R12 masked status after unmask", d, 32'h8);
    endtask

    task automatic t_eoi();
        logic [31:0] d;
        bus_wr(ca(0, 'h00), 2);
        bus_wr(ca(0, 'h08), 5);
        repeat (6) @(negedge clk);
        bus_wr(ca(0, 'h08), 4);
        bus_rd(8'(GB + 'h08), d); chk("R7 two raw bits", d, 32'h9);
        bus_rd(ca(3, 'h0C), d);
        bus_rd(8'(GB + 'h08), d); chk("R8 only ch3 cleared", d, 32'h1);
        chk("R8 ch3 irq low", 32'(irq_o[3]), 0);
        bus_rd(8'(GB + 'h00), d);
        bus_rd(8'(GB + 'h08), d); chk("R11 global clear", d, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_hold();
        t_periodic();
        t_free();
        t_mask();
        t_eoi();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule